// File: doc/BRIEF.md
# Dual-Lane Serial Converter Readout Engine

This block reads one full frame of results out of an eight-channel, 16-bit simultaneous-sampling converter running in its serial output mode. It watches the converter's conversion-in-progress signal; when that signal drops, the block pulls chip-select low and runs a serial clock whose half-period comes from a programmable divider. The divider lets the same design meet the lower clock limit that applies when the interface supply is low. Two data lines are captured side by side. Lane 0 carries channels 0 to 3 and lane 1 carries channels 4 to 7, each channel 16 bits long, most significant bit first.

The converter drives a new bit after each rising serial clock edge. The block samples each bit on the falling edge, half a period after it was launched. The converter also raises a first-channel marker shortly after chip-select falls. The block samples it together with the first bit and flags a misaligned frame when the marker is low. After the last bit, chip-select is released and the eight words are presented one per cycle in channel order, followed by a one-cycle done pulse.

Top module: `dual_lane_adc_reader`

## Requirements
- R1: While reset is low, `cs_n_o` and `sclk_o` are 1, and `word_valid_o`, `done_o` and `align_err_o` are 0.
- R2: When the block is idle and `busy_i` is sampled 1 on one clock edge and 0 on the next, `cs_n_o` is 0 from that second edge onward, with `sclk_o` still 1.
- R3: The serial clock half-period is `div_i` clock cycles, with 0 treated as 1. The value is captured when the frame starts. The first falling edge of `sclk_o` comes one half-period after chip-select falls, and each frame has exactly 64 falling edges.
- R4: Each lane bit is sampled on the clock edge that drives `sclk_o` low, most significant bit first. The first 16 bits of lane 0 form channel 0 and its last 16 bits form channel 3. Lane 1 fills channels 4 to 7 the same way. Words pass unchanged as two's complement.
- R5: One half-period after the 64th falling edge, `sclk_o` returns to 1 and `cs_n_o` rises on the same clock edge. `sclk_o` is 1 whenever `cs_n_o` is 1.
- R6: Starting in the cycle where `cs_n_o` rises, `word_valid_o` is 1 for eight consecutive cycles with `word_chan_o` equal to 0, 1, ..., 7.
- R7: `done_o` is 1 for exactly the one cycle after the channel 7 word.
- R8: `frst_i` is sampled on the first falling edge. If it is 0, `align_err_o` becomes 1; otherwise `align_err_o` becomes 0. The flag is cleared when the next frame starts and otherwise holds its value.
- R9: A fall of `busy_i` while a frame is in progress does not start another frame and does not change the captured words or the timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Converter conversion-in-progress signal, synchronous to clk |
| div_i | input | DIV_W (8) | Serial clock half-period in clk cycles (0 behaves as 1) |
| sdata_i | input | NUM_LANES (2) | Serial data lines; bit 0 = lane 0 (channels 0-3), bit 1 = lane 1 (channels 4-7) |
| frst_i | input | 1 | First-channel marker from the converter |
| cs_n_o | output | 1 | Chip-select to the converter, active low |
| sclk_o | output | 1 | Serial clock to the converter, idles high |
| word_valid_o | output | 1 | Strobe for a presented word |
| word_chan_o | output | CHAN_W (3) | Channel index of the presented word |
| word_data_o | output | WORD_W (16) | Two's-complement result of that channel |
| done_o | output | 1 | One-cycle pulse after the last word |
| align_err_o | output | 1 | First-channel marker was low at the first bit |

## Verification
The marker check and the capture of the first bit happen on the same clock edge, the first falling serial clock edge. The bench model drives the marker only while chip-select is low and the bit pointer is still in channel 0, so both are sampled in that cycle. Frames with the marker held low show whether the error flag is set while the most significant bits of channels 0 and 4 are still captured correctly. A second overlap occurs when a new busy fall lands in the middle of a shift. The bench injects one and then requires a single chip-select fall and unchanged words and timing.

// File: rtl/rdr_pkg.sv
`timescale 1ns/1ps
package rdr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_SETUP   = 3'd1,
      ST_SHIFT   = 3'd2,
      ST_PRESENT = 3'd3,
      ST_DONE    = 3'd4
   } rdr_state_e;
endpackage

// File: rtl/rdr_half_timer.sv
`timescale 1ns/1ps
module rdr_half_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [CNT_W-1:0] half_i,
   output logic             tick_o
);
   logic [CNT_W-1:0] cnt_q;

   // half_i is never zero here: the controller substitutes 1
   assign tick_o = run_i && (cnt_q == (half_i - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (!run_i || tick_o) cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/rdr_lane_shift.sv
`timescale 1ns/1ps
module rdr_lane_shift #(
   parameter int BITS = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            shift_i,
   input  logic            din_i,
   output logic [BITS-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q_o <= '0;
      else if (shift_i) q_o <= {q_o[BITS-2:0], din_i};
   end
endmodule

// File: rtl/rdr_frame_ctrl.sv
`timescale 1ns/1ps
module rdr_frame_ctrl
   import rdr_pkg::*;
#(
   parameter int LANE_BITS = 64,
   parameter int NUM_WORDS = 8,
   parameter int DIV_W     = 8,
   parameter int CHAN_W    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic              frst_i,
   input  logic              tick_i,
   output logic              run_o,
   output logic [DIV_W-1:0]  half_o,
   output logic              shift_o,
   output logic              cs_n_o,
   output logic              sclk_o,
   output logic              present_o,
   output logic [CHAN_W-1:0] idx_o,
   output logic              done_o,
   output logic              align_err_o
);
   localparam int BCNT_W = $clog2(LANE_BITS + 1);

   rdr_state_e        state_q;
   logic              busy_q;
   logic [BCNT_W-1:0] bit_q;
   logic              busy_fall;

   assign busy_fall = busy_q & ~busy_i;
   assign run_o     = (state_q == ST_SETUP) || (state_q == ST_SHIFT);
   assign shift_o   = run_o && tick_i && sclk_o;
   assign present_o = (state_q == ST_PRESENT);
   assign done_o    = (state_q == ST_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         busy_q      <= 1'b0;
         bit_q       <= '0;
         half_o      <= DIV_W'(1);
         cs_n_o      <= 1'b1;
         sclk_o      <= 1'b1;
         idx_o       <= '0;
         align_err_o <= 1'b0;
      end else begin
         busy_q <= busy_i;
         unique case (state_q)
            ST_IDLE: begin
               if (busy_fall) begin
                  state_q     <= ST_SETUP;
                  cs_n_o      <= 1'b0;
                  half_o      <= (div_i == '0) ? DIV_W'(1) : div_i;
                  bit_q       <= '0;
                  align_err_o <= 1'b0;
               end
            end
            ST_SETUP: begin
               if (tick_i) begin
                  align_err_o <= ~frst_i;
                  sclk_o      <= 1'b0;
                  bit_q       <= BCNT_W'(1);
                  state_q     <= ST_SHIFT;
               end
            end
            ST_SHIFT: begin
               if (tick_i) begin
                  if (sclk_o) begin
                     sclk_o <= 1'b0;
                     bit_q  <= bit_q + 1'b1;
                  end else begin
                     sclk_o <= 1'b1;
                     if (bit_q == BCNT_W'(LANE_BITS)) begin
                        cs_n_o  <= 1'b1;
                        idx_o   <= '0;
                        state_q <= ST_PRESENT;
                     end
                  end
               end
            end
            ST_PRESENT: begin
               idx_o <= idx_o + 1'b1;
               if (idx_o == CHAN_W'(NUM_WORDS - 1)) state_q <= ST_DONE;
            end
            ST_DONE:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dual_lane_adc_reader.sv
`timescale 1ns/1ps
module dual_lane_adc_reader #(
   parameter int WORD_W      = 16,
   parameter int CH_PER_LANE = 4,
   parameter int NUM_LANES   = 2,
   parameter int DIV_W       = 8,
   parameter int LANE_BITS   = WORD_W * CH_PER_LANE,
   parameter int NUM_WORDS   = NUM_LANES * CH_PER_LANE,
   parameter int CHAN_W      = $clog2(NUM_WORDS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 busy_i,
   input  logic [DIV_W-1:0]     div_i,
   input  logic [NUM_LANES-1:0] sdata_i,
   input  logic                 frst_i,
   output logic                 cs_n_o,
   output logic                 sclk_o,
   output logic                 word_valid_o,
   output logic [CHAN_W-1:0]    word_chan_o,
   output logic [WORD_W-1:0]    word_data_o,
   output logic                 done_o,
   output logic                 align_err_o
);
   // elaboration-time parameter checks
   if (WORD_W < 2) begin : g_bad_word
      $error("WORD_W must be at least 2");
   end
   if (CH_PER_LANE < 1 || NUM_LANES < 1) begin : g_bad_lanes
      $error("lane and channel counts must be positive");
   end
   if ((1 << CHAN_W) != NUM_WORDS || NUM_WORDS < 2) begin : g_bad_words
      $error("total channel count must be a power of two");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be positive");
   end

   logic              tick, run, shift, present;
   logic [DIV_W-1:0]  half;
   logic [CHAN_W-1:0] idx;
   logic [LANE_BITS-1:0] lane_q [NUM_LANES];
   logic [WORD_W-1:0]    words  [NUM_WORDS];

   rdr_half_timer #(.CNT_W(DIV_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .half_i (half),
      .tick_o (tick)
   );

   rdr_frame_ctrl #(
      .LANE_BITS (LANE_BITS),
      .NUM_WORDS (NUM_WORDS),
      .DIV_W     (DIV_W),
      .CHAN_W    (CHAN_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .busy_i      (busy_i),
      .div_i       (div_i),
      .frst_i      (frst_i),
      .tick_i      (tick),
      .run_o       (run),
      .half_o      (half),
      .shift_o     (shift),
      .cs_n_o      (cs_n_o),
      .sclk_o      (sclk_o),
      .present_o   (present),
      .idx_o       (idx),
      .done_o      (done_o),
      .align_err_o (align_err_o)
   );

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      rdr_lane_shift #(.BITS(LANE_BITS)) u_lane (
         .clk     (clk),
         .rst_n   (rst_n),
         .shift_i (shift),
         .din_i   (sdata_i[l]),
         .q_o     (lane_q[l])
      );
   end

   // channel c lives in lane c/CH_PER_LANE, earliest-shifted word first
   for (genvar c = 0; c < NUM_WORDS; c++) begin : g_word
      assign words[c] =
         lane_q[c / CH_PER_LANE][LANE_BITS-1-(c % CH_PER_LANE)*WORD_W -: WORD_W];
   end

   assign word_valid_o = present;
   assign word_chan_o  = idx;
   assign word_data_o  = present ? words[idx] : '0;
endmodule

// File: rtl/rdr_reader_checks.sv
`timescale 1ns/1ps
module rdr_reader_checks #(
   parameter int CHAN_W    = 3,
   parameter int NUM_WORDS = 8,
   parameter int FALLS     = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_i,
   input logic              cs_n_o,
   input logic              sclk_o,
   input logic              word_valid_o,
   input logic [CHAN_W-1:0] word_chan_o,
   input logic              done_o,
   input logic              align_err_o
);
   logic        sclk_d;
   logic [15:0] falls_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b1;
         falls_q <= '0;
      end else begin
         sclk_d <= sclk_o;
         if (cs_n_o)                 falls_q <= '0;
         else if (sclk_d && !sclk_o) falls_q <= falls_q + 1'b1;
         a_fall_limit_r3: assert (falls_q <= 16'(FALLS))
            else $error("more serial clock falls than one frame holds");
      end
   end

   p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_o |-> sclk_o);

   p_frame_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && cs_n_o && !word_valid_o && !done_o
       && $past(busy_i) && !busy_i) |=> !cs_n_o);

   p_chan_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o && word_chan_o != CHAN_W'(NUM_WORDS - 1))
      |=> (word_valid_o && word_chan_o == $past(word_chan_o) + 1'b1));

   p_first_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n_o) |-> (word_valid_o && word_chan_o == '0));

   p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o && word_chan_o == CHAN_W'(NUM_WORDS - 1)) |=> done_o);

   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o || done_o) |-> $stable(align_err_o));
endmodule

bind dual_lane_adc_reader rdr_reader_checks #(
   .CHAN_W    (CHAN_W),
   .NUM_WORDS (NUM_WORDS),
   .FALLS     (LANE_BITS)
) i_checks (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy_i       (busy_i),
   .cs_n_o       (cs_n_o),
   .sclk_o       (sclk_o),
   .word_valid_o (word_valid_o),
   .word_chan_o  (word_chan_o),
   .done_o       (done_o),
   .align_err_o  (align_err_o)
);

// File: tb/test_dual_lane_adc_reader.sv
`timescale 1ns/1ps
module test_dual_lane_adc_reader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        busy = 1'b0;
   logic [7:0]  div = 8'd1;
   logic [1:0]  sdata;
   logic        frst;
   logic        cs_n, sclk, wvalid, done, aerr;
   logic [2:0]  wchan;
   logic [15:0] wdata;

   int nchk = 0;
   int nerr = 0;
   int cyc  = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dual_lane_adc_reader i_dual_lane_adc_reader (
      .clk(clk), .rst_n(rst_n), .busy_i(busy), .div_i(div), .sdata_i(sdata),
      .frst_i(frst), .cs_n_o(cs_n), .sclk_o(sclk), .word_valid_o(wvalid),
      .word_chan_o(wchan), .word_data_o(wdata), .done_o(done), .align_err_o(aerr)
   );

   // converter model: MSB valid at chip-select fall, advance on sclk rise
   logic [63:0] lane_vec [2];
   logic        frst_en = 1'b1;
   int          ptr = 0;
   always @(negedge cs_n) ptr = 0;
   always @(posedge sclk) if (!cs_n) ptr = ptr + 1;
   always_comb begin
      for (int l = 0; l < 2; l++)
         sdata[l] = (!cs_n && ptr < 64) ? lane_vec[l][63 - ptr] : 1'b0;
      frst = frst_en && !cs_n && ptr < 16;
   end

   // monitor, sampled away from the active edge
   logic        prev_cs = 1'b1, prev_sclk = 1'b1;
   int          t_csf, t_csr, t_ff, t_lf, t_w0, t_w7, t_done;
   int          nfall, ndone, ncsf, exp_chan;
   bit          order_bad;
   logic [15:0] got [8];

   always @(negedge clk) begin
      if (prev_cs && !cs_n) begin t_csf = cyc; ncsf++; end
      if (!prev_cs && cs_n) t_csr = cyc;
      if (prev_sclk && !sclk && !cs_n) begin
         nfall++;
         if (nfall == 1) t_ff = cyc;
         t_lf = cyc;
      end
      if (wvalid) begin
         got[wchan] = wdata;
         if (int'(wchan) != exp_chan) order_bad = 1'b1;
         exp_chan++;
         if (wchan == 3'd0) t_w0 = cyc;
         if (wchan == 3'd7) t_w7 = cyc;
      end
      if (done) begin ndone++; t_done = cyc; end
      prev_cs   = cs_n;
      prev_sclk = sclk;
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   always @(posedge clk) if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      summary();
   end

   function automatic logic [15:0] exp_word(input logic [63:0] v0, input logic [63:0] v1, input int c);
      if (c < 4) return v0[63 - 16*c -: 16];
      return v1[63 - 16*(c-4) -: 16];
   endfunction

   task automatic run_frame(input logic [7:0] d, input bit fen,
                            input logic [63:0] v0, input logic [63:0] v1,
                            input bit inject, input string tag);
      int h;
      int t_bf;
      h = (d == 0) ? 1 : int'(d);
      @(posedge clk);
      nfall = 0; ndone = 0; ncsf = 0; exp_chan = 0; order_bad = 1'b0;
      t_csf = -1; t_csr = -1; t_ff = -1; t_lf = -1; t_w0 = -1; t_w7 = -1; t_done = -1;
      for (int c = 0; c < 8; c++) got[c] = 'x;
      lane_vec[0] = v0; lane_vec[1] = v1; frst_en = fen;
      @(negedge clk) begin div = d; busy = 1'b1; end
      @(negedge clk) busy = 1'b0;
      t_bf = cyc;
      if (inject) begin
         repeat (20) @(negedge clk);
         busy = 1'b1;
         @(negedge clk) busy = 1'b0;
         div = 8'd9;
      end
      for (int i = 0; i < 5000 && ndone == 0; i++) @(negedge clk);
      repeat (2) @(negedge clk);
      check(t_csf == t_bf + 1, {tag, " R2 cs fall cycle"}, t_csf, t_bf + 1);
      check(t_ff - t_csf == h, {tag, " R3 first fall delay"}, t_ff - t_csf, h);
      check(nfall == 64, {tag, " R3 fall count"}, nfall, 64);
      check(t_csr - t_lf == h, {tag, " R5 cs rise after last fall"}, t_csr - t_lf, h);
      for (int c = 0; c < 8; c++)
         check(got[c] === exp_word(v0, v1, c), {tag, " R4 word"}, int'(got[c]),
               int'(exp_word(v0, v1, c)));
      check(!order_bad && exp_chan == 8, {tag, " R6 channel order"}, exp_chan, 8);
      check(t_w0 == t_csr && t_w7 == t_w0 + 7, {tag, " R6 strobe timing"}, t_w7, t_csr + 7);
      check(ndone == 1 && t_done == t_w7 + 1, {tag, " R7 done pulse"}, t_done, t_w7 + 1);
      check(aerr == !fen, {tag, " R8 alignment flag"}, int'(aerr), int'(!fen));
      if (inject) check(ncsf == 1, {tag, " R9 single frame"}, ncsf, 1);
   endtask

   // {div[7:0], marker_enable, lane0[63:0], lane1[63:0]}
   localparam logic [136:0] VEC [5] = '{
      {8'd1, 1'b1, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210},
      {8'd2, 1'b1, 64'h8000_7FFF_FFFF_0000, 64'hA5A5_5A5A_0001_FFFE},
      {8'd3, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001},
      {8'd0, 1'b1, 64'h8001_4000_2000_1000, 64'h0800_0400_0200_8000},
      {8'd5, 1'b1, 64'hDEAD_BEEF_C0DE_F00D, 64'h1357_9BDF_2468_ACE0}
   };

   initial begin
      lane_vec[0] = '0; lane_vec[1] = '0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check(cs_n === 1'b1 && sclk === 1'b1, "R1 reset cs/sclk", {cs_n, sclk}, 2'b11);
      check(wvalid === 1'b0 && done === 1'b0 && aerr === 1'b0, "R1 reset outputs",
            {wvalid, done, aerr}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < 5; i++)
         run_frame(VEC[i][136:129], VEC[i][128], VEC[i][127:64], VEC[i][63:0], 1'b0,
                   $sformatf("vec%0d", i));

      // R8: flag cleared at next frame start after an error frame
      run_frame(8'd1, 1'b0, 64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888, 1'b0, "err");
      @(negedge clk) busy = 1'b1;
      @(negedge clk) busy = 1'b0;
      @(negedge clk);
      check(aerr === 1'b0 && cs_n === 1'b0, "R8 flag clears at frame start", int'(aerr), 0);
      // R1: reset in the middle of a frame
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(cs_n === 1'b1 && sclk === 1'b1 && aerr === 1'b0 && wvalid === 1'b0,
            "R1 mid-frame reset", {cs_n, sclk, aerr, wvalid}, 4'b1100);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R9: busy fall injected during the shift, divider change ignored
      run_frame(8'd2, 1'b1, 64'hCAFE_0BAD_F00D_7777, 64'h0F0F_F0F0_3C3C_C3C3, 1'b1, "inject");
      // recovery frame after reset and injection
      run_frame(8'd1, 1'b1, 64'h7FFF_8000_0001_FFFF, 64'h1234_5678_9ABC_DEF0, 1'b0, "after");
      summary();
   end
endmodule